// File: doc/BRIEF.md
# Neighbour Ring Mailbox

This block links a ring of processing cores with one-way, single-word mailboxes. Each core owns one outbound latch. Only the next core in the ring can read it, and the last core's latch feeds core 0. A core posts a 9-bit word with a single write request, and its neighbour collects the word with a single read request. Each latch has a data-available flag, which both sides can use for a light handshake that never needs shared memory.

A write can be made conditional, so that it does not overwrite a word that has not been read yet. A write can also clear the top bit (bit 8) of the word it stores. A read can report whether a fresh word was waiting. It can also split off bit 8 into a separate result, so that the top bit can serve as a control marker beside 8 bits of payload. All results are registered and appear on the clock after the request.

Top module: `ring_mbox`

## Requirements
- R1: The latch written by core i is read only by core (i+1) mod N_CORES, so core 0 reads the latch of core N_CORES-1. A read by any other core never returns that word.
- R2: A write stores the 9-bit word and sets the data-available flag. A read returns the stored word and clears the flag. A second checked read then reports valid = 0 and returns the same word.
- R3: A write with full-check set, made while the flag is set, is dropped. The old word is kept, and wr_fail of the writing core is 1 in the next cycle. In every other case wr_fail is 0 in the cycle after.
- R4: A write with mask set stores bit 8 as 0, whatever input bit 8 is.
- R5: A read with valid-check set gives rd_valid equal to the flag before the read. A read without valid-check gives rd_valid = 0. Either kind of read clears the flag.
- R6: A read with extract set returns bit 8 of rd_data as 0 and puts the stored bit 8 on rd_msb. A read without extract returns all 9 stored bits and rd_msb = 0.
- R7: A write without full-check always replaces the word and sets the flag, even when an unread word is lost.
- R8: When a write and a read hit the same latch in one clock, the read returns the word held before that clock. The flag then reflects the write: it is set if the write was accepted and cleared if the write was dropped.
- R9: Synchronous active-high reset clears every latch, every flag and every output to 0.
- R10: Results register on the clock edge after the request. rd_data, rd_valid and rd_msb hold their values until that core's next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | N_CORES | Write request, one bit per core |
| wr_data | input | N_CORES*DATA_W | Write word; core i uses slice i |
| wr_full_chk | input | N_CORES | Drop the write if the outbound latch is full |
| wr_mask_msb | input | N_CORES | Store bit 8 as 0 |
| wr_fail | output | N_CORES | Conditional write was dropped |
| rd_en | input | N_CORES | Read request from the inbound latch |
| rd_valid_chk | input | N_CORES | Report the flag state on rd_valid |
| rd_extract | input | N_CORES | Move bit 8 out to rd_msb |
| rd_data | output | N_CORES*DATA_W | Word read; core i uses slice i |
| rd_valid | output | N_CORES | Flag was set before a checked read |
| rd_msb | output | N_CORES | Stored bit 8 of an extracting read |

## Verification
The bench sends words with bit 8 set and with bit 8 clear through writer/reader pairs at several ring positions, including the wrap from the last core to core 0. This separates correct neighbour routing from wrong slice mapping. Checked writes go to both full and empty latches, and unchecked writes go to full latches. These cases tell the drop path apart from the overwrite path. Reads are made with and without valid-check and extract, so stale flags and a bit 8 that is not split off both show up. A read collides with an accepted write and with a dropped write in the same clock, and these cases expose any wrong write/read ordering.

// File: rtl/ring_mbox_pkg.sv
package ring_mbox_pkg;

  // Per-request options of the write side of one mailbox
  typedef struct packed {
    logic en;
    logic full_chk;
    logic mask_msb;
  } wr_ctl_t;

  // Per-request options of the read side of one mailbox
  typedef struct packed {
    logic en;
    logic valid_chk;
    logic extract;
  } rd_ctl_t;

endpackage

// File: rtl/mbox_wr_stage.sv
module mbox_wr_stage
  import ring_mbox_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  wr_ctl_t           ctl,
  input  logic [DATA_W-1:0] din,
  input  logic              full,
  output logic              accept,
  output logic              fail_nxt,
  output logic [DATA_W-1:0] store_word
);

  localparam int MSB = DATA_W - 1;

  logic blocked;

  always_comb begin
    blocked  = ctl.full_chk && full;
    accept   = ctl.en && !blocked;
    fail_nxt = ctl.en && blocked;
    store_word = din;
    if (ctl.mask_msb) begin
      store_word[MSB] = 1'b0;
    end
  end

endmodule

// File: rtl/mbox_rd_stage.sv
module mbox_rd_stage
  import ring_mbox_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  rd_ctl_t           ctl,
  input  logic [DATA_W-1:0] held,
  input  logic              full,
  output logic [DATA_W-1:0] data_nxt,
  output logic              valid_nxt,
  output logic              msb_nxt
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    data_nxt  = held;
    valid_nxt = ctl.valid_chk ? full : 1'b0;
    msb_nxt   = 1'b0;
    if (ctl.extract) begin
      data_nxt[MSB] = 1'b0;
      msb_nxt       = held[MSB];
    end
  end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
  import ring_mbox_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_ctl_t           wr_ctl,
  input  logic [DATA_W-1:0] wr_word,
  output logic              wr_fail,
  input  rd_ctl_t           rd_ctl,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              rd_msb
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] latch_q;
  logic              full_q;
  logic              accept;
  logic              fail_nxt;
  logic [DATA_W-1:0] store_word;
  logic [DATA_W-1:0] data_nxt;
  logic              valid_nxt;
  logic              msb_nxt;

  mbox_wr_stage #(.DATA_W(DATA_W)) u_wr (
    .ctl        (wr_ctl),
    .din        (wr_word),
    .full       (full_q),
    .accept     (accept),
    .fail_nxt   (fail_nxt),
    .store_word (store_word)
  );

  mbox_rd_stage #(.DATA_W(DATA_W)) u_rd (
    .ctl       (rd_ctl),
    .held      (latch_q),
    .full      (full_q),
    .data_nxt  (data_nxt),
    .valid_nxt (valid_nxt),
    .msb_nxt   (msb_nxt)
  );

  // Storage and flag: an accepted write wins over a same-cycle read
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      full_q  <= 1'b0;
    end else begin
      if (accept) begin
        latch_q <= store_word;
      end
      if (accept) begin
        full_q <= 1'b1;
      end else if (rd_ctl.en) begin
        full_q <= 1'b0;
      end
    end
  end

  // Registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_fail  <= 1'b0;
      rd_word  <= '0;
      rd_valid <= 1'b0;
      rd_msb   <= 1'b0;
    end else begin
      wr_fail <= fail_nxt;
      if (rd_ctl.en) begin
        rd_word  <= data_nxt;
        rd_valid <= valid_nxt;
        rd_msb   <= msb_nxt;
      end
    end
  end

  // R2: an accepted write leaves the flag set
  p_write_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl.en && !(wr_ctl.full_chk && full_q)) |=> full_q);

  // R2: a read with no write empties the latch
  p_read_clears_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl.en && !wr_ctl.en) |=> !full_q);

  // R3: a dropped write keeps the old word and reports the failure
  p_drop_keeps_word_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl.en && wr_ctl.full_chk && full_q) |=> (wr_fail && $stable(latch_q)));

  // R4: a masked write stores a clear top bit
  p_mask_clears_msb_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl.en && wr_ctl.mask_msb && !(wr_ctl.full_chk && full_q)) |=> !latch_q[MSB]);

  // R6: an extracting read never returns a set top bit
  p_extract_clears_msb_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl.en && rd_ctl.extract) |=> !rd_word[MSB]);

  // R10: read results stay put while no read is made
  p_hold_results_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_ctl.en |=> ($stable(rd_word) && $stable(rd_valid) && $stable(rd_msb)));

endmodule

// File: rtl/ring_mbox.sv
module ring_mbox
  import ring_mbox_pkg::*;
#(
  parameter int N_CORES = 8,
  parameter int DATA_W  = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_CORES-1:0]          wr_en,
  input  logic [N_CORES*DATA_W-1:0]   wr_data,
  input  logic [N_CORES-1:0]          wr_full_chk,
  input  logic [N_CORES-1:0]          wr_mask_msb,
  output logic [N_CORES-1:0]          wr_fail,
  input  logic [N_CORES-1:0]          rd_en,
  input  logic [N_CORES-1:0]          rd_valid_chk,
  input  logic [N_CORES-1:0]          rd_extract,
  output logic [N_CORES*DATA_W-1:0]   rd_data,
  output logic [N_CORES-1:0]          rd_valid,
  output logic [N_CORES-1:0]          rd_msb
);

  // Slot i belongs to writer core i and is read by core (i+1) mod N_CORES (R1)
  for (genvar i = 0; i < N_CORES; i++) begin : g_slot
    localparam int NXT = (i + 1) % N_CORES;

    wr_ctl_t wctl;
    rd_ctl_t rctl;

    assign wctl = '{en: wr_en[i], full_chk: wr_full_chk[i], mask_msb: wr_mask_msb[i]};
    assign rctl = '{en: rd_en[NXT], valid_chk: rd_valid_chk[NXT], extract: rd_extract[NXT]};

    mbox_slot #(.DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_ctl   (wctl),
      .wr_word  (wr_data[i*DATA_W +: DATA_W]),
      .wr_fail  (wr_fail[i]),
      .rd_ctl   (rctl),
      .rd_word  (rd_data[NXT*DATA_W +: DATA_W]),
      .rd_valid (rd_valid[NXT]),
      .rd_msb   (rd_msb[NXT])
    );
  end

  // R9: the cycle after reset every result is clear
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (wr_fail == '0 && rd_valid == '0 && rd_msb == '0 && rd_data == '0));

endmodule

// File: tb/ring_mbox_test.sv
module ring_mbox_test;

  localparam int N = 8;
  localparam int W = 9;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   wr_en = '0, wr_full_chk = '0, wr_mask_msb = '0;
  logic [N*W-1:0] wr_data = '0;
  logic [N-1:0]   rd_en = '0, rd_valid_chk = '0, rd_extract = '0;
  logic [N-1:0]   wr_fail, rd_valid, rd_msb;
  logic [N*W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ring_mbox #(.N_CORES(N), .DATA_W(W)) uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_data(wr_data), .wr_full_chk(wr_full_chk),
    .wr_mask_msb(wr_mask_msb), .wr_fail(wr_fail),
    .rd_en(rd_en), .rd_valid_chk(rd_valid_chk), .rd_extract(rd_extract),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_msb(rd_msb)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        we;
    logic [2:0]  wc;
    logic [8:0]  wd;
    logic        wchk, wmsk;
    logic        re;
    logic [2:0]  rc;
    logic        rchk, rext;
    logic        xfail;
    logic [8:0]  xdata;
    logic        xvalid, xmsb;
  } vec_t;

  localparam int NV = 20;
  //   tag   we wc wd      chk msk  re rc chk ext  fail data    vld msb
  localparam vec_t TBL [0:NV-1] = '{
    '{"R2 ", 1'b1,3'd0,9'h1A5,1'b0,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R2 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd1,1'b1,1'b0, 1'b0,9'h1A5,1'b1,1'b0},
    '{"R2 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd1,1'b1,1'b0, 1'b0,9'h1A5,1'b0,1'b0},
    '{"R4 ", 1'b1,3'd7,9'h155,1'b0,1'b1, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R1 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd0,1'b1,1'b1, 1'b0,9'h055,1'b1,1'b0},
    '{"R3 ", 1'b1,3'd3,9'h1F0,1'b0,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R3 ", 1'b1,3'd3,9'h10F,1'b1,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b1,9'h000,1'b0,1'b0},
    '{"R6 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd4,1'b1,1'b1, 1'b0,9'h0F0,1'b1,1'b1},
    '{"R3 ", 1'b1,3'd3,9'h00C,1'b1,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R7 ", 1'b1,3'd3,9'h0AA,1'b0,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R7 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd4,1'b1,1'b0, 1'b0,9'h0AA,1'b1,1'b0},
    '{"R8 ", 1'b1,3'd5,9'h133,1'b0,1'b0, 1'b1,3'd6,1'b1,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R8 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd6,1'b1,1'b0, 1'b0,9'h133,1'b1,1'b0},
    '{"R1 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd2,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R2 ", 1'b1,3'd2,9'h1FF,1'b0,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R5 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd3,1'b0,1'b0, 1'b0,9'h1FF,1'b0,1'b0},
    '{"R5 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd3,1'b1,1'b1, 1'b0,9'h0FF,1'b0,1'b1},
    '{"R7 ", 1'b1,3'd3,9'h111,1'b0,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0},
    '{"R8 ", 1'b1,3'd3,9'h122,1'b1,1'b0, 1'b1,3'd4,1'b1,1'b0, 1'b1,9'h111,1'b1,1'b0},
    '{"R8 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd4,1'b1,1'b0, 1'b0,9'h111,1'b0,1'b0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    wr_en = '0; wr_full_chk = '0; wr_mask_msb = '0; wr_data = '0;
    rd_en = '0; rd_valid_chk = '0; rd_extract = '0;
  endtask

  // Drive at a falling edge, results are registered at the next rising edge
  task automatic apply(input vec_t v);
    @(negedge clk);
    clear_inputs();
    if (v.we) begin
      wr_en[v.wc] = 1'b1; wr_full_chk[v.wc] = v.wchk; wr_mask_msb[v.wc] = v.wmsk;
      wr_data[v.wc*W +: W] = v.wd;
    end
    if (v.re) begin
      rd_en[v.rc] = 1'b1; rd_valid_chk[v.rc] = v.rchk; rd_extract[v.rc] = v.rext;
    end
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: outputs clear straight after reset
    check("R9", "wr_fail after reset", int'(wr_fail), 0);
    check("R9", "rd_data after reset", int'(rd_data == '0), 1);
    check("R9", "rd_valid after reset", int'(rd_valid), 0);
    check("R9", "rd_msb after reset", int'(rd_msb), 0);

    for (int k = 0; k < NV; k++) begin
      apply(TBL[k]);
      if (TBL[k].we)
        check(string'(TBL[k].tag), $sformatf("vec %0d wr_fail", k),
              int'(wr_fail[TBL[k].wc]), int'(TBL[k].xfail));
      if (TBL[k].re) begin
        check(string'(TBL[k].tag), $sformatf("vec %0d rd_data", k),
              int'(rd_data[TBL[k].rc*W +: W]), int'(TBL[k].xdata));
        check(string'(TBL[k].tag), $sformatf("vec %0d rd_valid", k),
              int'(rd_valid[TBL[k].rc]), int'(TBL[k].xvalid));
        check(string'(TBL[k].tag), $sformatf("vec %0d rd_msb", k),
              int'(rd_msb[TBL[k].rc]), int'(TBL[k].xmsb));
      end
    end

    // R10: idle cycle, read results hold and the fail flag drops
    @(negedge clk);
    check("R10", "rd_data hold core4", int'(rd_data[4*W +: W]), 'h111);
    check("R10", "wr_fail drops core3", int'(wr_fail[3]), 0);

    // R9: reset in mid-run empties a loaded latch
    apply('{"R9 ", 1'b1,3'd6,9'h0AB,1'b0,1'b0, 1'b0,3'd0,1'b0,1'b0, 1'b0,9'h000,1'b0,1'b0});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply('{"R9 ", 1'b0,3'd0,9'h000,1'b0,1'b0, 1'b1,3'd7,1'b1,1'b0, 1'b0,9'h000,1'b0,1'b0});
    check("R9", "rd_data after mid reset", int'(rd_data[7*W +: W]), 0);
    check("R9", "rd_valid after mid reset", int'(rd_valid[7]), 0);

    done = 1;
    finish_run();
  end

endmodule